// File: doc/BRIEF.md
# Serial EEPROM Sequential Word Reader

This block is a bus master that fetches a run of consecutive 16-bit words from a three-wire serial EEPROM (clock, select, data out, data in). A single start pulse supplies a first address, a word count and an address-width choice of 6 or 8 bits. The controller then performs one complete, independent READ transaction for each word.

Each transaction has the same shape. Select rises, and one idle serial period follows with the data line low. The controller then sends the start bit, the two-bit READ opcode and the address. It clocks in seventeen bits. The first of these is the device's leading zero, which is dropped. Select then falls and stays low for a configurable number of serial periods before the next transaction begins.

Every word is presented on a one-cycle valid strobe together with its position in the run. A one-cycle done pulse closes the run. The high and low phases of the serial clock are set independently, as counts of system clocks. This lets the device's minimum timing (high phase at least 750 ns, low phase at least 250 ns, select held for at least about 1 µs) be met at any system clock frequency.

Top module: `sprom_burst_rd`

## Requirements
- R1: For each word, `ser_sel_o` rises and exactly one full serial clock period (one rising edge) passes with `ser_sel_o` high and `ser_out_o` low before the start bit is sent.
- R2: After that period, the bits 1, 1, 0 are sent on `ser_out_o`, one per rising edge of `ser_clk_o`: the start bit, then the READ opcode 10.
- R3: The address follows, most significant bit first. It is 8 bits wide when `addr8_i`=1 and 6 bits wide (the low 6 bits) when `addr8_i`=0. Word i of a run uses address (base+i) modulo 2^width and is reported with `word_idx_o`=i.
- R4: Seventeen bits are sampled from `ser_in_i` on the rising edges that follow the last address bit. The first is discarded. The other 16 form `word_o`, MSB first, and are presented with a one-cycle `word_vld_o` pulse.
- R5: After the seventeenth sampled bit, `ser_sel_o` falls and stays low for GAP_SLOTS full serial periods (the clock keeps running) before the next word or the end of the run.
- R6: `ser_clk_o` is high for exactly HI_CYC system clocks and low for exactly LO_CYC system clocks in every period. `ser_out_o` and `ser_sel_o` change only while `ser_clk_o` is low.
- R7: A run of N words produces exactly N `word_vld_o` pulses. It then produces one `done_o` pulse in the cycle after the last gap period ends, with `busy_o` low in that cycle.
- R8: A start with `word_cnt_i`=0 gives `done_o` in the next cycle. `busy_o`, `ser_sel_o` and `ser_clk_o` stay low.
- R9: A start pulse while `busy_o` is high is ignored: the run in progress keeps its address, count and width.
- R10: After reset, `ser_clk_o`, `ser_sel_o`, `ser_out_o`, `busy_o`, `word_vld_o` and `done_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a run (accepted only when idle) |
| base_addr_i | input | ADDR_W | First word address |
| word_cnt_i | input | CNT_W | Number of words to read |
| addr8_i | input | 1 | 1: 8-bit addresses, 0: 6-bit addresses |
| ser_in_i | input | 1 | Serial data from the memory |
| ser_clk_o | output | 1 | Serial clock |
| ser_sel_o | output | 1 | Chip select, active high |
| ser_out_o | output | 1 | Serial data to the memory |
| busy_o | output | 1 | Run in progress |
| word_vld_o | output | 1 | One-cycle strobe for a fetched word |
| word_o | output | DATA_W | Fetched word |
| word_idx_o | output | CNT_W | Position of the word in the run |
| done_o | output | 1 | One-cycle end-of-run pulse |

## Verification
Each word's strobe is due one system cycle after the high phase of the seventeenth read period ends, which is the same cycle in which select drops. `done_o` is due one cycle after the last gap period. A zero-count start answers one cycle after it is accepted. The bench does not predict these absolute cycles from a schedule. Its memory model and monitor record strobes, select edges and serial clock edges as they occur, and each scenario task checks the recorded counts and values only after `done_o` plus a short settling window. Phase widths are checked by counting system clocks between successive serial clock transitions. A run of length N is checked against N frames, N words and N×GAP_SLOTS gap rising edges.

// File: rtl/sprom_pkg.sv
package sprom_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FRAME,
      ST_CMD,
      ST_ADDR,
      ST_READ,
      ST_GAP
   } seq_st_t;

   localparam int CMD_BITS = 3;
   // start bit, then the READ opcode, sent left to right
   localparam logic [CMD_BITS-1:0] READ_CMD = 3'b110;

endpackage

// File: rtl/sprom_sck_gen.sv
module sprom_sck_gen #(
   parameter int HI_CYC = 75,
   parameter int LO_CYC = 25
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic sclk_o,
   output logic rise_o,
   output logic slot_end_o
);
   localparam int LONGEST = (HI_CYC > LO_CYC) ? HI_CYC : LO_CYC;
   localparam int CW      = $clog2(LONGEST + 1);
   localparam logic [CW-1:0] LO_LAST = CW'(LO_CYC - 1);
   localparam logic [CW-1:0] HI_LAST = CW'(HI_CYC - 1);

   logic [CW-1:0] cnt_q;
   logic          hi_q;

   assign rise_o     = run_i & ~hi_q & (cnt_q == LO_LAST);
   assign slot_end_o = run_i &  hi_q & (cnt_q == HI_LAST);
   assign sclk_o     = hi_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         hi_q  <= 1'b0;
      end else if (!run_i) begin
         cnt_q <= '0;
         hi_q  <= 1'b0;
      end else if (rise_o) begin
         cnt_q <= '0;
         hi_q  <= 1'b1;
      end else if (slot_end_o) begin
         cnt_q <= '0;
         hi_q  <= 1'b0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/sprom_in_sync.sv
module sprom_in_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   generate
      if (STAGES == 0) begin : g_direct
         assign q_o = d_i;
      end else begin : g_chain
         logic [STAGES-1:0] ff_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ff_q <= '0;
            else        ff_q <= (ff_q << 1) | STAGES'(d_i);
         end
         assign q_o = ff_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/sprom_rx_shift.sv
module sprom_rx_shift #(
   parameter int WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             shift_i,
   input  logic             bit_i,
   output logic [WIDTH-1:0] data_o
);
   // WIDTH+1 shifts per word push the leading dummy bit out of the top
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       data_o <= '0;
      else if (shift_i) data_o <= {data_o[WIDTH-2:0], bit_i};
   end
endmodule

// File: rtl/sprom_frame_seq.sv
module sprom_frame_seq
   import sprom_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int SHORT_AW  = 6,
   parameter int CNT_W     = 9,
   parameter int DATA_W    = 16,
   parameter int GAP_SLOTS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic [CNT_W-1:0]  cnt_i,
   input  logic              addr8_i,
   input  logic              rise_i,
   input  logic              slot_end_i,
   input  logic [DATA_W-1:0] rx_i,
   output logic              busy_o,
   output logic              cs_o,
   output logic              mosi_o,
   output logic              capture_o,
   output logic              word_vld_o,
   output logic [DATA_W-1:0] word_o,
   output logic [CNT_W-1:0]  word_idx_o,
   output logic              done_o
);
   localparam int RD_SLOTS  = DATA_W + 1;
   localparam int MAX_A     = (ADDR_W > RD_SLOTS) ? ADDR_W : RD_SLOTS;
   localparam int MAX_B     = (GAP_SLOTS > CMD_BITS) ? GAP_SLOTS : CMD_BITS;
   localparam int MAX_SLOTS = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int BN_W      = $clog2(MAX_SLOTS);

   localparam logic [BN_W-1:0] CMD_LAST = BN_W'(CMD_BITS - 1);
   localparam logic [BN_W-1:0] RD_LAST  = BN_W'(RD_SLOTS - 1);
   localparam logic [BN_W-1:0] GAP_LAST = BN_W'(GAP_SLOTS - 1);

   seq_st_t             st_q;
   logic [BN_W-1:0]     bit_q;
   logic [ADDR_W-1:0]   base_q;
   logic [CNT_W-1:0]    cnt_q;
   logic [CNT_W-1:0]    idx_q;
   logic                wide_q;

   logic [BN_W-1:0]     addr_last;
   logic [ADDR_W-1:0]   addr_cur;
   logic [ADDR_W-1:0]   addr_sh;
   logic [CMD_BITS-1:0] cmd_sh;

   assign addr_last = wide_q ? BN_W'(ADDR_W - 1) : BN_W'(SHORT_AW - 1);
   assign addr_cur  = base_q + ADDR_W'(idx_q);
   assign addr_sh   = addr_cur >> (addr_last - bit_q);
   assign cmd_sh    = READ_CMD << bit_q;

   assign busy_o    = (st_q != ST_IDLE);
   assign cs_o      = (st_q != ST_IDLE) && (st_q != ST_GAP);
   assign capture_o = rise_i && (st_q == ST_READ);

   always_comb begin
      unique case (st_q)
         ST_CMD:  mosi_o = cmd_sh[CMD_BITS-1];
         ST_ADDR: mosi_o = addr_sh[0];
         default: mosi_o = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         bit_q      <= '0;
         base_q     <= '0;
         cnt_q      <= '0;
         idx_q      <= '0;
         wide_q     <= 1'b0;
         word_vld_o <= 1'b0;
         word_o     <= '0;
         word_idx_o <= '0;
         done_o     <= 1'b0;
      end else begin
         word_vld_o <= 1'b0;
         done_o     <= 1'b0;
         if (st_q == ST_IDLE) begin
            if (start_i) begin
               base_q <= base_i;
               cnt_q  <= cnt_i;
               wide_q <= addr8_i;
               idx_q  <= '0;
               bit_q  <= '0;
               if (cnt_i == '0) done_o <= 1'b1;
               else             st_q   <= ST_FRAME;
            end
         end else if (slot_end_i) begin
            bit_q <= bit_q + 1'b1;
            unique case (st_q)
               ST_FRAME: begin
                  st_q  <= ST_CMD;
                  bit_q <= '0;
               end
               ST_CMD: if (bit_q == CMD_LAST) begin
                  st_q  <= ST_ADDR;
                  bit_q <= '0;
               end
               ST_ADDR: if (bit_q == addr_last) begin
                  st_q  <= ST_READ;
                  bit_q <= '0;
               end
               ST_READ: if (bit_q == RD_LAST) begin
                  st_q       <= ST_GAP;
                  bit_q      <= '0;
                  word_vld_o <= 1'b1;
                  word_o     <= rx_i;
                  word_idx_o <= idx_q;
               end
               ST_GAP: if (bit_q == GAP_LAST) begin
                  bit_q <= '0;
                  if (idx_q == cnt_q - 1'b1) begin
                     st_q   <= ST_IDLE;
                     done_o <= 1'b1;
                  end else begin
                     idx_q <= idx_q + 1'b1;
                     st_q  <= ST_FRAME;
                  end
               end
               default: st_q <= ST_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/sprom_burst_rd.sv
module sprom_burst_rd #(
   parameter int ADDR_W    = 8,
   parameter int SHORT_AW  = 6,
   parameter int CNT_W     = 9,
   parameter int DATA_W    = 16,
   parameter int HI_CYC    = 75,
   parameter int LO_CYC    = 25,
   parameter int GAP_SLOTS = 2,
   parameter int IN_SYNC   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] base_addr_i,
   input  logic [CNT_W-1:0]  word_cnt_i,
   input  logic              addr8_i,
   input  logic              ser_in_i,
   output logic              ser_clk_o,
   output logic              ser_sel_o,
   output logic              ser_out_o,
   output logic              busy_o,
   output logic              word_vld_o,
   output logic [DATA_W-1:0] word_o,
   output logic [CNT_W-1:0]  word_idx_o,
   output logic              done_o
);
   generate
      if (SHORT_AW < 1 || SHORT_AW > ADDR_W) begin : g_bad_aw
         $error("SHORT_AW must lie in 1..ADDR_W");
      end
      if (HI_CYC < 1) begin : g_bad_hi
         $error("HI_CYC must be at least 1");
      end
      if (LO_CYC < IN_SYNC + 2) begin : g_bad_lo
         $error("LO_CYC must cover the input synchronizer plus two cycles");
      end
      if (GAP_SLOTS < 1 || CNT_W < 1 || DATA_W < 2) begin : g_bad_misc
         $error("GAP_SLOTS, CNT_W and DATA_W out of range");
      end
   endgenerate

   logic              rise;
   logic              slot_end;
   logic              din_sync;
   logic              capture;
   logic [DATA_W-1:0] rx_word;

   sprom_sck_gen #(
      .HI_CYC (HI_CYC),
      .LO_CYC (LO_CYC)
   ) u_sck (
      .clk        (clk),
      .rst_n      (rst_n),
      .run_i      (busy_o),
      .sclk_o     (ser_clk_o),
      .rise_o     (rise),
      .slot_end_o (slot_end)
   );

   sprom_in_sync #(
      .STAGES (IN_SYNC)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (ser_in_i),
      .q_o   (din_sync)
   );

   sprom_rx_shift #(
      .WIDTH (DATA_W)
   ) u_rx (
      .clk     (clk),
      .rst_n   (rst_n),
      .shift_i (capture),
      .bit_i   (din_sync),
      .data_o  (rx_word)
   );

   sprom_frame_seq #(
      .ADDR_W    (ADDR_W),
      .SHORT_AW  (SHORT_AW),
      .CNT_W     (CNT_W),
      .DATA_W    (DATA_W),
      .GAP_SLOTS (GAP_SLOTS)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .base_i     (base_addr_i),
      .cnt_i      (word_cnt_i),
      .addr8_i    (addr8_i),
      .rise_i     (rise),
      .slot_end_i (slot_end),
      .rx_i       (rx_word),
      .busy_o     (busy_o),
      .cs_o       (ser_sel_o),
      .mosi_o     (ser_out_o),
      .capture_o  (capture),
      .word_vld_o (word_vld_o),
      .word_o     (word_o),
      .word_idx_o (word_idx_o),
      .done_o     (done_o)
   );
endmodule

// File: rtl/sprom_burst_rd_chk.sv
module sprom_burst_rd_chk #(
   parameter int CNT_W = 9
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic [CNT_W-1:0] word_cnt_i,
   input logic             ser_clk_o,
   input logic             ser_sel_o,
   input logic             ser_out_o,
   input logic             busy_o,
   input logic             word_vld_o,
   input logic             done_o
);
   AST_IDLE_QUIET:   assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (!ser_sel_o && !ser_clk_o));                                  // R8
   AST_OUT_HOLD_HI:  assert property (@(posedge clk) disable iff (!rst_n)
      ser_clk_o |-> $stable(ser_out_o));                                        // R6
   AST_SEL_HOLD_HI:  assert property (@(posedge clk) disable iff (!rst_n)
      ser_clk_o |-> $stable(ser_sel_o));                                        // R6
   AST_VLD_PULSE:    assert property (@(posedge clk) disable iff (!rst_n)
      word_vld_o |=> !word_vld_o);                                              // R4
   AST_DONE_IDLE:    assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);                                                      // R7
   AST_ZERO_COUNT:   assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o && word_cnt_i == '0) |=> (done_o && !busy_o));        // R8
   AST_RUN_OPENS:    assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o && word_cnt_i != '0) |=> (busy_o && ser_sel_o));      // R1
endmodule

bind sprom_burst_rd sprom_burst_rd_chk #(.CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_i    (start_i),
   .word_cnt_i (word_cnt_i),
   .ser_clk_o  (ser_clk_o),
   .ser_sel_o  (ser_sel_o),
   .ser_out_o  (ser_out_o),
   .busy_o     (busy_o),
   .word_vld_o (word_vld_o),
   .done_o     (done_o)
);

// File: tb/sprom_burst_rd_tb.sv
module sprom_burst_rd_tb_top;
   localparam int HI  = 4;
   localparam int LO  = 5;
   localparam int GAP = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [7:0]  base = '0;
   logic [8:0]  cnt = '0;
   logic        a8 = 1'b0;
   logic        din = 1'b0;
   logic        sclk, sel, dout, busy, vld, done;
   logic [15:0] word;
   logic [8:0]  widx;

   always #5 clk = ~clk;

   sprom_burst_rd #(
      .HI_CYC(HI), .LO_CYC(LO), .GAP_SLOTS(GAP), .IN_SYNC(2)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start), .base_addr_i(base),
      .word_cnt_i(cnt), .addr8_i(a8), .ser_in_i(din),
      .ser_clk_o(sclk), .ser_sel_o(sel), .ser_out_o(dout), .busy_o(busy),
      .word_vld_o(vld), .word_o(word), .word_idx_o(widx), .done_o(done)
   );

   int n_chk = 0;
   int n_bad = 0;

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] memw(input int a);
      logic [7:0] b;
      b = 8'(a);
      return {b, ~b} ^ 16'hC35A;
   endfunction

   // ---------------- memory model and monitor ----------------
   int          cur_aw = 8;
   int          exp_base = 0;
   logic        sclk_q = 1'b0, sel_q = 1'b0;
   logic        started = 1'b0;
   logic        bitv [0:63];
   int          nbits = 0, pre = 0, frames = 0, sel_rises = 0;
   int          pre_bad = 0, cmd_bad = 0, addr_bad = 0, len_bad = 0;
   int          gap_rises = 0, hi_run = 0, lo_run = 0, w_bad = 0;
   int          n_got = 0, n_done = 0, idx_bad = 0;
   logic [15:0] got [0:15];

   task automatic clear_mon();
      frames = 0; pre_bad = 0; cmd_bad = 0; addr_bad = 0; len_bad = 0;
      gap_rises = 0; w_bad = 0; n_got = 0; n_done = 0; idx_bad = 0;
      sel_rises = 0;
   endtask

   always @(posedge clk) begin
      int a;
      int k;
      logic [15:0] mw;
      if (rst_n) begin
         if (busy) begin
            if (sclk && !sclk_q) begin
               if (lo_run != LO) w_bad++;
               lo_run = 0;
            end
            if (!sclk && sclk_q) begin
               if (hi_run != HI) w_bad++;
               hi_run = 0;
            end
            if (sclk) hi_run++; else lo_run++;
         end else begin
            hi_run = 0; lo_run = 0;
         end
         if (sel && !sel_q) sel_rises++;
         if (!sel) begin
            if (sel_q) begin
               if (pre != 1) pre_bad++;
               if (nbits != 3 + cur_aw + 17) len_bad++;
               if (!(bitv[0] == 1'b1 && bitv[1] == 1'b1 && bitv[2] == 1'b0)) cmd_bad++;
               a = 0;
               for (int j = 0; j < cur_aw; j++) a = (a << 1) | int'(bitv[3 + j]);
               if (a != ((exp_base + frames) & ((1 << cur_aw) - 1))) addr_bad++;
               frames++;
            end
            if (busy && sclk && !sclk_q) gap_rises++;
            started = 1'b0; nbits = 0; pre = 0;
            din <= 1'b0;
         end else begin
            if (sclk && !sclk_q) begin
               if (!started) begin
                  if (dout) begin started = 1'b1; bitv[0] = 1'b1; nbits = 1; end
                  else pre++;
               end else begin
                  if (nbits < 64) bitv[nbits] = dout;
                  nbits++;
               end
            end
            if (!sclk && sclk_q && started && nbits >= 3 + cur_aw) begin
               a = 0;
               for (int j = 0; j < cur_aw; j++) a = (a << 1) | int'(bitv[3 + j]);
               mw = memw(a);
               k = nbits - (3 + cur_aw);
               if (k >= 1 && k <= 16) din <= mw[16 - k];
               else                   din <= 1'b0;
            end
         end
         if (vld) begin
            if (int'(widx) != n_got) idx_bad++;
            if (widx < 16) got[widx[3:0]] = word;
            n_got++;
         end
         if (done) n_done++;
      end
      sclk_q = sclk;
      sel_q  = sel;
   end

   // ---------------- scenarios ----------------
   task automatic kick(input logic [7:0] b, input logic [8:0] c, input logic w8);
      @(negedge clk);
      base = b; cnt = c; a8 = w8; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done();
      while (n_done == 0) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   task automatic check_run(input int b, input int c, input int aw);
      chk("R1 frames opened", frames, c);
      chk("R1 idle period before start bit", pre_bad, 0);
      chk("R2 command bits 110", cmd_bad, 0);
      chk("R3 address bits", addr_bad, 0);
      chk("R3 word index order", idx_bad, 0);
      chk("R4 bits per frame", len_bad, 0);
      for (int i = 0; i < c; i++)
         chk("R4 word value", int'(got[i]), int'(memw((b + i) & ((1 << aw) - 1))));
      chk("R5 gap periods", gap_rises, GAP * c);
      chk("R6 phase widths", w_bad, 0);
      chk("R7 word count", n_got, c);
      chk("R7 single done", n_done, 1);
      chk("R7 idle after done", int'(busy), 0);
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R10 sclk in reset", int'(sclk), 0);
      chk("R10 sel in reset", int'(sel), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R10 outputs after reset", int'({sclk, sel, dout, busy, vld, done}), 0);
   endtask

   task automatic t_run(input int b, input int c, input logic w8);
      clear_mon();
      cur_aw = w8 ? 8 : 6;
      exp_base = b;
      kick(8'(b), 9'(c), w8);
      wait_done();
      check_run(b, c, cur_aw);
   endtask

   task automatic t_zero();
      clear_mon();
      kick(8'd5, 9'd0, 1'b1);
      chk("R8 done next cycle", int'(done), 1);
      chk("R8 not busy", int'(busy), 0);
      repeat (20) @(negedge clk);
      chk("R8 no select activity", sel_rises, 0);
      chk("R8 no words", n_got, 0);
   endtask

   task automatic t_busy_ignore();
      clear_mon();
      cur_aw = 8;
      exp_base = 10;
      kick(8'd10, 9'd3, 1'b1);
      repeat (60) @(negedge clk);
      base = 8'd100; cnt = 9'd7; a8 = 1'b0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done();
      chk("R9 count kept", n_got, 3);
      chk("R9 address kept", addr_bad, 0);
      for (int i = 0; i < 3; i++)
         chk("R9 words from first request", int'(got[i]), int'(memw(10 + i)));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      t_reset();
      t_run(8'h21, 4, 1'b1);    // 8-bit addresses
      t_run(62, 5, 1'b0);       // 6-bit addresses, wraps past 63
      t_run(254, 3, 1'b1);      // 8-bit wrap past 255
      t_run(7, 1, 1'b0);        // single word
      t_zero();
      t_busy_ignore();
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule